// File: doc/BRIEF.md
# Eight-Bit Flag-Producing ALU

This block is the arithmetic and logic datapath of a small accumulator machine. Each cycle it takes a 4-bit operation code, two 8-bit operands and the machine's current status flags. Combinationally it produces the 8-bit result, the next value of all five status flags (negative, overflow, half-carry, zero, carry) and a mask that shows which flags the operation defines. The carry input to add, subtract and the rotates is the carry bit of the block's own flag register.

A small flag register sits inside the block. It loads the next flag value on every clock edge where `step` is high and holds its value otherwise. Flags that the current operation does not define pass through from the register unchanged. Register files, operand fetch and instruction decode are left to the surrounding core.

Top module: `alu8_flagged`

## Requirements
- R1: While `rst_n` is low, and after it is released, `flags` reads 0.
- R2: Codes 1 (OR), 2 (AND) and 3 (XOR) return the bitwise result of `opa` with `opb`. They write only N and Z: N is bit 7 of the result and Z is 1 when the result is zero.
- R3: Code 0 (load) returns `opb` and writes only N and Z from it.
- R4: Code 4 (compare) returns `opa` unchanged and writes N, Z and C. N and Z come from `opa - opb` mod 256. C is 1 exactly when `opa >= opb`, compared as unsigned numbers.
- R5: Code 5 (add with carry) returns `(opa + opb + C) mod 256`. C is the carry out of bit 7, H is the carry out of bit 3, V is signed overflow, and N and Z come from the result.
- R6: Code 6 (subtract with borrow) returns `(opa - opb - (1 - C)) mod 256`. C is 1 when the unsigned difference did not go negative. H is 1 when the low-nibble difference did not go negative. V is signed overflow, and N and Z come from the result.
- R7: Codes 7 (increment) and 8 (decrement) return `opa ± 1` wrapping modulo 256. They write only N and Z.
- R8: Code 9 shifts `opa` left with a 0 into bit 0 and old bit 7 into C. Code 10 shifts right with a 0 into bit 7 and old bit 0 into C. Both write N, Z and C.
- R9: Code 11 rotates `opa` left with old C into bit 0 and old bit 7 into C. Code 12 rotates right with old C into bit 7 and old bit 0 into C. Both write N, Z and C.
- R10: Code 13 (store) returns `opb` and writes no flag.
- R11: Codes 14 and 15 return `opa` and write no flag.
- R12: `flag_we` and `flags_next` use the bit order {N,V,H,Z,C}, with N at bit 4 and C at bit 0. A flag bit whose `flag_we` bit is 0 equals the same bit of `flags`.
- R13: On a rising clock edge with `step` high, `flags` takes the value of `flags_next`. With `step` low, `flags` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of the flag register |
| step | input | 1 | Clock enable for the flag register |
| op | input | 4 | Operation code |
| opa | input | 8 | First operand (accumulator side) |
| opb | input | 8 | Second operand |
| res | output | 8 | Operation result |
| flag_we | output | 5 | Flags defined by the operation, {N,V,H,Z,C} |
| flags_next | output | 5 | Flag value that the next enabled edge would load |
| flags | output | 5 | Registered status flags, {N,V,H,Z,C} |

## Verification
The only state in the block is the flag register. Any fault in it appears at `flags` on the first enabled edge after the fault. In the same cycle it also appears at `flags_next` for every flag the operation does not write. A wrong carry bit also changes `res` of the next add, subtract or rotate. A reference model in the bench tracks the flags and compares every output in every cycle, so a fault is reported in the cycle it first becomes visible.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    typedef enum logic [3:0] {
        OP_LOAD  = 4'd0,
        OP_OR    = 4'd1,
        OP_AND   = 4'd2,
        OP_XOR   = 4'd3,
        OP_CMP   = 4'd4,
        OP_ADC   = 4'd5,
        OP_SBC   = 4'd6,
        OP_INC   = 4'd7,
        OP_DEC   = 4'd8,
        OP_SHL   = 4'd9,
        OP_SHR   = 4'd10,
        OP_ROL   = 4'd11,
        OP_ROR   = 4'd12,
        OP_STORE = 4'd13,
        OP_RSV0  = 4'd14,
        OP_RSV1  = 4'd15
    } alu_op_e;

    typedef enum logic [2:0] {
        AS_ADD,
        AS_SUB,
        AS_CMP,
        AS_INC,
        AS_DEC
    } addsub_mode_e;

    localparam int NFLAG = 5;
    localparam int FL_N  = 4;
    localparam int FL_V  = 3;
    localparam int FL_H  = 2;
    localparam int FL_Z  = 1;
    localparam int FL_C  = 0;

endpackage

// File: rtl/alu8_bitwise.sv
module alu8_bitwise
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e        sel,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   y
);
    always_comb begin
        case (sel)
            OP_OR:   y = a | b;
            OP_AND:  y = a & b;
            OP_XOR:  y = a ^ b;
            default: y = b;
        endcase
    end
endmodule

// File: rtl/alu8_addsub.sv
module alu8_addsub
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  addsub_mode_e   mode,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic           cin,
    output logic [W-1:0]   y,
    output logic           cout,
    output logic           hout,
    output logic           vout
);
    localparam int HB = W / 2;

    logic [W-1:0]  b_eff;
    logic          c_eff;
    logic [W:0]    full_d;
    logic [HB:0]   low_d;

    always_comb begin
        case (mode)
            AS_SUB:  begin b_eff = ~b;        c_eff = cin;  end
            AS_CMP:  begin b_eff = ~b;        c_eff = 1'b1; end
            AS_INC:  begin b_eff = '0;        c_eff = 1'b1; end
            AS_DEC:  begin b_eff = '1;        c_eff = 1'b0; end
            default: begin b_eff = b;         c_eff = cin;  end
        endcase
        full_d = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, c_eff};
        low_d  = {1'b0, a[HB-1:0]} + {1'b0, b_eff[HB-1:0]} + {{HB{1'b0}}, c_eff};
        y      = full_d[W-1:0];
        cout   = full_d[W];
        hout   = low_d[HB];
        vout   = (a[W-1] == b_eff[W-1]) && (full_d[W-1] != a[W-1]);
    end
endmodule

// File: rtl/alu8_shifter.sv
module alu8_shifter #(
    parameter int W = 8
) (
    input  logic           to_right,
    input  logic           through_c,
    input  logic           cin,
    input  logic [W-1:0]   a,
    output logic [W-1:0]   y,
    output logic           cout
);
    logic fill;

    always_comb begin
        fill = through_c & cin;
        if (to_right) begin
            y    = {fill, a[W-1:1]};
            cout = a[0];
        end else begin
            y    = {a[W-2:0], fill};
            cout = a[W-1];
        end
    end
endmodule

// File: rtl/alu8_flagged.sv
module alu8_flagged
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           step,
    input  logic [3:0]     op,
    input  logic [W-1:0]   opa,
    input  logic [W-1:0]   opb,
    output logic [W-1:0]   res,
    output logic [4:0]     flag_we,
    output logic [4:0]     flags_next,
    output logic [4:0]     flags
);
    localparam logic [NFLAG-1:0] WE_NZ  = NFLAG'((1 << FL_N) | (1 << FL_Z));
    localparam logic [NFLAG-1:0] WE_NZC = WE_NZ | NFLAG'(1 << FL_C);
    localparam logic [NFLAG-1:0] WE_ALL = '1;

    typedef struct packed {
        logic [W-1:0]      res;
        logic [NFLAG-1:0]  we;
        logic [NFLAG-1:0]  fl;
    } alu_step_t;

    alu_op_e           op_e;
    alu_step_t         nx_d;
    logic [NFLAG-1:0]  flags_q;
    addsub_mode_e      as_mode;
    logic [W-1:0]      bw_y, as_y, sh_y, nz_src;
    logic              as_c, as_h, as_v, sh_c;
    logic [NFLAG-1:0]  cand;

    assign op_e = alu_op_e'(op);

    always_comb begin
        case (op_e)
            OP_SBC:  as_mode = AS_SUB;
            OP_CMP:  as_mode = AS_CMP;
            OP_INC:  as_mode = AS_INC;
            OP_DEC:  as_mode = AS_DEC;
            default: as_mode = AS_ADD;
        endcase
    end

    alu8_bitwise #(.W(W)) u_bw (
        .sel (op_e),
        .a   (opa),
        .b   (opb),
        .y   (bw_y)
    );

    alu8_addsub #(.W(W)) u_as (
        .mode (as_mode),
        .a    (opa),
        .b    (opb),
        .cin  (flags_q[FL_C]),
        .y    (as_y),
        .cout (as_c),
        .hout (as_h),
        .vout (as_v)
    );

    alu8_shifter #(.W(W)) u_sh (
        .to_right  (op_e == OP_SHR || op_e == OP_ROR),
        .through_c (op_e == OP_ROL || op_e == OP_ROR),
        .cin       (flags_q[FL_C]),
        .a         (opa),
        .y         (sh_y),
        .cout      (sh_c)
    );

    always_comb begin
        nx_d     = '0;
        nx_d.res = opa;
        nx_d.we  = '0;
        nz_src   = opa;
        cand     = '0;
        case (op_e)
            OP_LOAD, OP_OR, OP_AND, OP_XOR: begin
                nx_d.res = bw_y;
                nx_d.we  = WE_NZ;
                nz_src   = bw_y;
            end
            OP_STORE: nx_d.res = bw_y;
            OP_CMP: begin
                nx_d.we     = WE_NZC;
                nz_src      = as_y;
                cand[FL_C]  = as_c;
            end
            OP_ADC, OP_SBC: begin
                nx_d.res    = as_y;
                nx_d.we     = WE_ALL;
                nz_src      = as_y;
                cand[FL_C]  = as_c;
                cand[FL_H]  = as_h;
                cand[FL_V]  = as_v;
            end
            OP_INC, OP_DEC: begin
                nx_d.res = as_y;
                nx_d.we  = WE_NZ;
                nz_src   = as_y;
            end
            OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
                nx_d.res    = sh_y;
                nx_d.we     = WE_NZC;
                nz_src      = sh_y;
                cand[FL_C]  = sh_c;
            end
            default: ;
        endcase
        cand[FL_N] = nz_src[W-1];
        cand[FL_Z] = (nz_src == '0);
        nx_d.fl    = (cand & nx_d.we) | (flags_q & ~nx_d.we);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flags_q <= '0;
        else if (step)
            flags_q <= nx_d.fl;
    end

    assign res        = nx_d.res;
    assign flag_we    = nx_d.we;
    assign flags_next = nx_d.fl;
    assign flags      = flags_q;

    // R13
    load_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (flags == $past(flags_next)));

    // R13
    hold_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(flags));

    // R12
    untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags_next ^ flags) & ~flag_we) == '0);

    // R11
    reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op >= 4'd14) |-> (flag_we == '0 && res == opa));

    // R4
    cmp_borrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 4'd4) |-> (flag_we[FL_C] && flags_next[FL_C] == (opa >= opb) && res == opa));

    // R7
    inc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 4'd7) |-> (res == W'(opa + 1'b1) && flag_we[FL_C] == 1'b0));

endmodule

// File: tb/sim_alu8_flagged.sv
module sim_alu8_flagged;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       step = 1'b0;
    logic [3:0] op = '0;
    logic [7:0] opa = '0, opb = '0;
    logic [7:0] res;
    logic [4:0] flag_we, flags_next, flags;

    int n_tests = 0;
    int n_fail  = 0;
    int mflags  = 0;
    bit done    = 0;

    alu8_flagged u0 (
        .clk(clk), .rst_n(rst_n), .step(step), .op(op), .opa(opa), .opb(opb),
        .res(res), .flag_we(flag_we), .flags_next(flags_next), .flags(flags)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic string tag_of(int o);
        case (o)
            0: return "R3";
            1, 2, 3: return "R2";
            4: return "R4";
            5: return "R5";
            6: return "R6";
            7, 8: return "R7";
            9, 10: return "R8";
            11, 12: return "R9";
            13: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic check(string rq, string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    function automatic int sgn(int v);
        return (v > 127) ? v - 256 : v;
    endfunction

    // reference: returns {res, we, next flags}; flag order {N,V,H,Z,C}
    task automatic model(input int o, input int a, input int b, input int f,
                         output int r, output int we, output int nf);
        int c, n, v, h, z, cf, nzv, s, hs;
        c = f & 1;
        r = a; we = 0; nzv = a; cf = 0; v = 0; h = 0;
        case (o)
            0: begin r = b; we = 5'b10010; nzv = b; end
            1: begin r = a | b; we = 5'b10010; nzv = r; end
            2: begin r = a & b; we = 5'b10010; nzv = r; end
            3: begin r = a ^ b; we = 5'b10010; nzv = r; end
            4: begin nzv = (a - b) & 255; cf = (a >= b); we = 5'b10011; end
            5: begin
                s = a + b + c; r = s & 255; nzv = r; cf = (s > 255);
                h = ((a % 16) + (b % 16) + c) > 15;
                s = sgn(a) + sgn(b) + c; v = (s > 127 || s < -128);
                we = 5'b11111;
            end
            6: begin
                s = a - b - (1 - c); r = s & 255; nzv = r; cf = (s >= 0);
                hs = (a % 16) - (b % 16) - (1 - c); h = (hs >= 0);
                s = sgn(a) - sgn(b) - (1 - c); v = (s > 127 || s < -128);
                we = 5'b11111;
            end
            7: begin r = (a + 1) & 255; nzv = r; we = 5'b10010; end
            8: begin r = (a + 255) & 255; nzv = r; we = 5'b10010; end
            9: begin r = (a * 2) & 255; cf = a / 128; nzv = r; we = 5'b10011; end
            10: begin r = a / 2; cf = a % 2; nzv = r; we = 5'b10011; end
            11: begin r = (a * 2 + c) & 255; cf = a / 128; nzv = r; we = 5'b10011; end
            12: begin r = a / 2 + c * 128; cf = a % 2; nzv = r; we = 5'b10011; end
            13: begin r = b; end
            default: ;
        endcase
        n = nzv / 128; z = (nzv == 0);
        nf = (n << 4) | (v << 3) | (h << 2) | (z << 1) | cf;
        nf = (nf & we) | (f & ~we & 31);
    endtask

    task automatic run_op(int o, int a, int b, bit en);
        int r, we, nf;
        @(negedge clk);
        op = 4'(o); opa = 8'(a); opb = 8'(b); step = en;
        #(CLK_PERIOD/4);
        model(o, a, b, mflags, r, we, nf);
        check(tag_of(o), "res", int'(res), r);
        check("R12", "flag_we", int'(flag_we), we);
        check(tag_of(o), "flags_next", int'(flags_next), nf);
        check("R13", "flags", int'(flags), mflags);
        @(posedge clk);
        if (en) mflags = nf;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1", "flags in reset", int'(flags), 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R1", "flags after reset", int'(flags), 0);

        // R5: carry, half carry and overflow corners
        run_op(5, 8'h0F, 8'h01, 1);
        run_op(5, 8'h7F, 8'h01, 1);
        run_op(5, 8'hFF, 8'h01, 1);
        run_op(5, 8'h80, 8'h80, 1);
        run_op(5, 8'h00, 8'h00, 1);
        // R6: borrow corners, with carry in both states
        run_op(6, 8'h10, 8'h01, 1);
        run_op(6, 8'h00, 8'h01, 1);
        run_op(6, 8'h80, 8'h01, 1);
        run_op(6, 8'h05, 8'h05, 1);
        // R4: equal, greater and smaller
        run_op(4, 8'h40, 8'h40, 1);
        run_op(4, 8'h41, 8'h40, 1);
        run_op(4, 8'h3F, 8'h40, 1);
        // R7: wrap at both ends, carry kept
        run_op(7, 8'hFF, 0, 1);
        run_op(8, 8'h00, 0, 1);
        // R8/R9: shifts and rotates with carry both ways
        run_op(9, 8'h81, 0, 1);
        run_op(12, 8'h02, 0, 1);
        run_op(11, 8'h40, 0, 1);
        run_op(10, 8'h01, 0, 1);
        run_op(11, 8'h80, 0, 1);
        // R2/R3/R10/R11
        run_op(1, 8'hF0, 8'h0F, 1);
        run_op(2, 8'hF0, 8'h0F, 1);
        run_op(3, 8'hAA, 8'hAA, 1);
        run_op(0, 0, 8'h80, 1);
        run_op(13, 8'h12, 8'h00, 1);
        run_op(14, 8'h34, 8'h56, 1);
        run_op(15, 8'h00, 8'hFF, 1);
        // R13: hold with step low
        run_op(5, 8'hFF, 8'hFF, 0);
        run_op(0, 0, 0, 0);

        for (int i = 0; i < 4000; i++)
            run_op(int'($urandom_range(15)), int'($urandom_range(255)),
                   int'($urandom_range(255)), ($urandom_range(7) != 0));

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule